// File: doc/BRIEF.md
# Delta-Sigma Converter Output Sequencer

This block is the digital control for a single-cycle delta-sigma converter. It runs a fixed loop on the oscillator clock. First it converts for a set number of clock periods. It then waits with the result held. When a host selects it, the block shifts the result out on a serial data line, and a new conversion starts on its own once the transfer is over. The modulator and the decimating filter are not part of this block. A stub supplies the 20 data bits and three status bits, and the block captures them on the last conversion cycle.

The host controls everything through an active-low select and a bidirectional clock pin. There are no configuration registers. The clock mode is taken from the clock pin level at each select falling edge. In external mode the host clocks the data out. In internal mode the block drives the clock pin itself at a fraction of the oscillator rate. While select is low and no transfer is in progress, the data line shows whether a result is ready. Raising select in the middle of a transfer abandons it and restarts conversion.

Top module: `adcseq_top`

## Requirements
- R1: While reset is held, and until select has passed through the synchroniser, `sdoOe` and `sckOe` are low. The block leaves reset in the converting state.
- R2: A conversion lasts exactly CONV_CYCLES clock cycles, counted from reset release or from the end of the previous transfer. The block then enters sleep.
- R3: In sleep, the captured word stays unchanged however long `csN` stays high, even if `dataIn` or `statusIn` change.
- R4: `sdoOe` is the inverse of `csN`, delayed by two clock cycles. With select low outside a transfer, `sdo` is 1 while converting and 0 once the result is ready.
- R5: The output word is 24 bits, sent most significant bit first. Bit 23 is a 0 ready flag. Bits 22..20 are `statusIn[2:0]`. Bits 19..0 are `dataIn[19:0]`, all as captured on the final conversion cycle.
- R6: In external mode, `sdo` moves to the next bit after each falling edge of `sckIn`. After the 24th falling edge a new conversion begins.
- R7: Clock pulses applied after the 24th bit read 1 on `sdo`.
- R8: A rise of `csN` during a transfer aborts it. A fresh conversion of the full length follows.
- R9: The level of `sckIn` at the `csN` falling edge picks the mode: 1 selects internal, 0 selects external.
- R10: In internal mode, `sckOe` is high for the transfer. `sckOut` has a period of SCK_DIV clocks, low for the first half and high for the second. Data advances at each falling edge. After 24 periods, `sckOe` drops and conversion restarts.
- R11: `sckOe` is low in external mode and whenever no transfer is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rstN | input | 1 | Active-low asynchronous reset |
| csN | input | 1 | Active-low chip select |
| sckIn | input | 1 | Level seen on the serial clock pin |
| sckOut | output | 1 | Serial clock driven in internal mode |
| sckOe | output | 1 | Drive enable for the serial clock pin |
| sdo | output | 1 | Serial data / ready status |
| sdoOe | output | 1 | Drive enable for the serial data line |
| dataIn | input | 20 | Conversion result from the stub |
| statusIn | input | 3 | Status bits from the stub |

## Verification
The bench shortens CONV_CYCLES to 600 and leaves the word widths and SCK_DIV=8 at their defaults. With this setting, several full conversions fit in one short run. That makes the exact edge between converting and ready measurable, and it leaves room for a full-length restart after an abort. Both clock modes, the trailing pulses and a long sleep with changing stub inputs can then be covered back to back.

// File: rtl/adcseq_pkg.sv
package adcseq_pkg;
  typedef enum logic [1:0] {
    ST_CONV  = 2'd0,
    ST_SLEEP = 2'd1,
    ST_OUT   = 2'd2
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;        // capture stub word
    logic shift;       // advance to next bit
    logic showWord;    // sdo carries the shift register
    logic converting;  // ready flag value when not shifting
  } dpCtrl_t;
endpackage

// File: rtl/adcseq_sync.sv
module adcseq_sync #(
  parameter int WIDTH = 1,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage1 <= RESET_VAL;
      q      <= RESET_VAL;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/adcseq_ctrl.sv
module adcseq_ctrl
  import adcseq_pkg::*;
#(
  parameter int CONV_CYCLES = 20510,
  parameter int WORD_BITS   = 24,
  parameter int SCK_DIV     = 8
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    csSync,
  input  logic    sckSync,
  output dpCtrl_t dpCtrl,
  output logic    sdoOe,
  output logic    sckOut,
  output logic    sckOe
);
  localparam int CONV_W = $clog2(CONV_CYCLES);
  localparam int BIT_W  = $clog2(WORD_BITS);
  localparam int DIV_W  = $clog2(SCK_DIV);
  localparam int HALF   = SCK_DIV / 2;

  seqState_t         state;
  logic [CONV_W-1:0] convCnt;
  logic [BIT_W-1:0]  bitCnt;
  logic [DIV_W-1:0]  divCnt;
  logic              intMode;
  logic              csPrev;
  logic              sckPrev;

  logic csFall, csRise, sckFall, divWrap, shiftNow, lastBit, convDone;

  assign csFall   = csPrev & ~csSync;
  assign csRise   = ~csPrev & csSync;
  assign sckFall  = sckPrev & ~sckSync;
  assign divWrap  = (divCnt == DIV_W'(SCK_DIV - 1));
  assign lastBit  = (bitCnt == BIT_W'(WORD_BITS - 1));
  assign convDone = (state == ST_CONV) && (convCnt == CONV_W'(CONV_CYCLES - 1));
  assign shiftNow = (state == ST_OUT) && !csRise && (intMode ? divWrap : sckFall);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_CONV;
      convCnt <= '0;
      bitCnt  <= '0;
      divCnt  <= '0;
      intMode <= 1'b0;
      csPrev  <= 1'b1;
      sckPrev <= 1'b0;
    end else begin
      csPrev  <= csSync;
      sckPrev <= sckSync;
      if (csFall && state != ST_OUT) intMode <= sckSync;
      case (state)
        ST_CONV: begin
          if (convDone) begin
            state   <= ST_SLEEP;
            convCnt <= '0;
          end else begin
            convCnt <= convCnt + 1'b1;
          end
        end
        ST_SLEEP: begin
          if (!csSync) begin
            state  <= ST_OUT;
            bitCnt <= '0;
            divCnt <= '0;
          end
        end
        ST_OUT: begin
          if (csRise) begin
            state   <= ST_CONV;
            convCnt <= '0;
          end else begin
            if (intMode) divCnt <= divWrap ? '0 : divCnt + 1'b1;
            if (shiftNow) begin
              if (lastBit) begin
                state   <= ST_CONV;
                convCnt <= '0;
              end else begin
                bitCnt <= bitCnt + 1'b1;
              end
            end
          end
        end
        default: state <= ST_CONV;
      endcase
    end
  end

  assign dpCtrl.load       = convDone;
  assign dpCtrl.shift      = shiftNow;
  assign dpCtrl.showWord   = (state == ST_OUT);
  assign dpCtrl.converting = (state == ST_CONV);

  assign sdoOe  = ~csSync;
  assign sckOe  = (state == ST_OUT) && intMode;
  assign sckOut = sckOe && (divCnt >= DIV_W'(HALF));

  // R2: leaving conversion only after the full count
  a_r2_conv_len: assert property (@(posedge clk) disable iff (!rstN)
    ($past(state) == ST_CONV && state == ST_SLEEP) |-> $past(convCnt) == CONV_W'(CONV_CYCLES - 1));

  // R8: select rise mid-transfer returns to conversion
  a_r8_abort: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_OUT && csRise) |=> (state == ST_CONV && convCnt == '0));

  // R6: last shifted bit ends the transfer
  a_r6_last_bit: assert property (@(posedge clk) disable iff (!rstN)
    (shiftNow && lastBit) |=> state == ST_CONV);

  // R9: mode is frozen for the whole transfer
  a_r9_mode_hold: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_OUT && $past(state) == ST_OUT) |-> $stable(intMode));
endmodule

// File: rtl/adcseq_datapath.sv
module adcseq_datapath
  import adcseq_pkg::*;
#(
  parameter int DATA_BITS   = 20,
  parameter int STATUS_BITS = 4,
  parameter int WORD_BITS   = DATA_BITS + STATUS_BITS
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  dpCtrl_t                dpCtrl,
  input  logic [DATA_BITS-1:0]   dataIn,
  input  logic [STATUS_BITS-2:0] statusIn,
  output logic                   sdo
);
  logic [WORD_BITS-1:0] shiftReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
    end else if (dpCtrl.load) begin
      shiftReg <= {1'b0, statusIn, dataIn};
    end else if (dpCtrl.shift) begin
      shiftReg <= {shiftReg[WORD_BITS-2:0], 1'b1};
    end
  end

  assign sdo = dpCtrl.showWord ? shiftReg[WORD_BITS-1] : dpCtrl.converting;

  // R5: captured word layout
  a_r5_load_word: assert property (@(posedge clk) disable iff (!rstN)
    dpCtrl.load |=> shiftReg == {1'b0, $past(statusIn), $past(dataIn)});

  // R3: no strobe, no change
  a_r3_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!dpCtrl.load && !dpCtrl.shift) |=> $stable(shiftReg));

  // R7: ones enter behind the word
  a_r7_fill: assert property (@(posedge clk) disable iff (!rstN)
    dpCtrl.shift |=> shiftReg[0]);
endmodule

// File: rtl/adcseq_top.sv
module adcseq_top
  import adcseq_pkg::*;
#(
  parameter int CONV_CYCLES = 20510,
  parameter int DATA_BITS   = 20,
  parameter int STATUS_BITS = 4,
  parameter int SCK_DIV     = 8
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   csN,
  input  logic                   sckIn,
  output logic                   sckOut,
  output logic                   sckOe,
  output logic                   sdo,
  output logic                   sdoOe,
  input  logic [DATA_BITS-1:0]   dataIn,
  input  logic [STATUS_BITS-2:0] statusIn
);
  localparam int WORD_BITS = DATA_BITS + STATUS_BITS;

  logic [1:0] pinSync;
  dpCtrl_t    dpCtrl;

  adcseq_sync #(.WIDTH(2), .RESET_VAL(2'b10)) u_sync (
    .clk (clk),
    .rstN(rstN),
    .d   ({csN, sckIn}),
    .q   (pinSync)
  );

  adcseq_ctrl #(
    .CONV_CYCLES(CONV_CYCLES),
    .WORD_BITS  (WORD_BITS),
    .SCK_DIV    (SCK_DIV)
  ) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .csSync (pinSync[1]),
    .sckSync(pinSync[0]),
    .dpCtrl (dpCtrl),
    .sdoOe  (sdoOe),
    .sckOut (sckOut),
    .sckOe  (sckOe)
  );

  adcseq_datapath #(
    .DATA_BITS  (DATA_BITS),
    .STATUS_BITS(STATUS_BITS),
    .WORD_BITS  (WORD_BITS)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .dpCtrl  (dpCtrl),
    .dataIn  (dataIn),
    .statusIn(statusIn),
    .sdo     (sdo)
  );
endmodule

// File: tb/adcseq_top_tb.sv
module adcseq_top_tb;
  localparam int CONV = 600;
  localparam int DIV  = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        csN = 1'b0;
  logic        sckDrv = 1'b0;
  logic [19:0] dataIn = 20'hA5C3E;
  logic [2:0]  statusIn = 3'b101;
  logic        sckOut, sckOe, sdo, sdoOe;
  wire         sckPin = sckOe ? sckOut : sckDrv;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  adcseq_top #(.CONV_CYCLES(CONV), .SCK_DIV(DIV)) u_dut (
    .clk(clk), .rstN(rstN), .csN(csN), .sckIn(sckPin),
    .sckOut(sckOut), .sckOe(sckOe), .sdo(sdo), .sdoOe(sdoOe),
    .dataIn(dataIn), .statusIn(statusIn)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask

  // external clock read of n bits, returns bits MSB first
  task automatic readExt(input int n, output logic [31:0] word);
    word = '0;
    for (int i = 0; i < n; i++) begin
      sckDrv = 1'b1;
      waitN(4);
      word = {word[30:0], sdo};
      check(sckOe == 1'b0, "R11 sckOe in external mode", sckOe, 0);
      sckDrv = 1'b0;
      waitN(4);
    end
  endtask

  task automatic t_reset_and_length();
    waitN(3);
    check(sdoOe == 1'b0, "R1 sdoOe in reset", sdoOe, 0);
    check(sckOe == 1'b0, "R1 sckOe in reset", sckOe, 0);
    rstN = 1'b1;
    check(sdoOe == 1'b0, "R1 sdoOe before sync", sdoOe, 0);
    waitN(CONV - 1);
    check(sdoOe == 1'b1, "R4 sdoOe with select low", sdoOe, 1);
    check(sdo == 1'b1, "R2 still converting at CONV-1", sdo, 1);
    waitN(1);
    check(sdo == 1'b0, "R2 ready at CONV", sdo, 0);
  endtask

  task automatic t_ext_read();
    logic [31:0] w;
    logic [31:0] exp = {8'h0, 1'b0, statusIn, dataIn};
    readExt(24, w);
    check(w[23:0] == exp[23:0], "R5 R6 external word", w, exp);
    readExt(8, w);
    check(w[7:0] == 8'hFF, "R7 trailing pulses", w[7:0], 8'hFF);
    check(sdo == 1'b1, "R6 conversion after word", sdo, 1);
  endtask

  task automatic t_sleep_hold();
    logic [31:0] w;
    logic [31:0] exp;
    csN = 1'b1;
    waitN(3);
    check(sdoOe == 1'b0, "R4 hi-z with select high", sdoOe, 0);
    dataIn = 20'h1F0E7; statusIn = 3'b010;
    exp = {8'h0, 1'b0, 3'b010, 20'h1F0E7};
    waitN(CONV + 50);
    dataIn = 20'h0F00F; statusIn = 3'b111;
    waitN(3 * CONV);
    check(sdoOe == 1'b0, "R4 hi-z in sleep", sdoOe, 0);
    sckDrv = 1'b0;
    csN = 1'b0;
    waitN(4);
    check(sdo == 1'b0, "R4 ready flag in sleep", sdo, 0);
    readExt(24, w);
    check(w[23:0] == exp[23:0], "R3 R5 word held through sleep", w, exp);
  endtask

  task automatic t_abort();
    logic [31:0] w;
    logic [31:0] exp;
    csN = 1'b1;
    dataIn = 20'h3C3C3; statusIn = 3'b001;
    waitN(CONV + 20);
    csN = 1'b0;
    waitN(4);
    readExt(5, w);
    check(w[4:0] == 5'b00010, "R5 first five bits", w[4:0], 5'b00010);
    csN = 1'b1;
    waitN(4);
    csN = 1'b0;
    waitN(4);
    check(sdo == 1'b1, "R8 converting after abort", sdo, 1);
    waitN(CONV - 40);
    check(sdo == 1'b1, "R8 restart has full length", sdo, 1);
    waitN(60);
    check(sdo == 1'b0, "R8 ready after new conversion", sdo, 0);
    exp = {8'h0, 1'b0, 3'b001, 20'h3C3C3};
    readExt(24, w);
    check(w[23:0] == exp[23:0], "R8 word after abort", w, exp);
  endtask

  task automatic t_internal();
    logic [31:0] w = '0;
    logic prev;
    int got = 0;
    int lastRise = -1;
    int cyc = 0;
    int badPeriod = 0;
    logic [31:0] exp;
    csN = 1'b1;
    dataIn = 20'h96E1B; statusIn = 3'b110;
    exp = {8'h0, 1'b0, 3'b110, 20'h96E1B};
    sckDrv = 1'b1;
    waitN(CONV + 80);
    csN = 1'b0;
    waitN(5);
    check(sckOe == 1'b1, "R9 internal mode selected", sckOe, 1);
    check(sckOut == 1'b0, "R10 clock starts low", sckOut, 0);
    prev = sckOut;
    while (got < 24 && cyc < 1000) begin
      waitN(1);
      cyc++;
      if (!prev && sckOut) begin
        w = {w[30:0], sdo};
        if (lastRise >= 0 && cyc - lastRise != DIV) badPeriod++;
        lastRise = cyc;
        got++;
      end
      prev = sckOut;
    end
    check(got == 24, "R10 24 internal clocks", got, 24);
    check(w[23:0] == exp[23:0], "R10 internal word", w, exp);
    check(badPeriod == 0, "R10 clock period", badPeriod, 0);
    waitN(DIV);
    check(sckOe == 1'b0, "R10 R11 clock released", sckOe, 0);
    check(sdo == 1'b1, "R10 conversion restarted", sdo, 1);
  endtask

  initial begin
    t_reset_and_length();
    t_ext_read();
    t_sleep_hold();
    t_abort();
    t_internal();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule